// File: doc/BRIEF.md
# Eight-bit modulus down-counter timer

This block is a free-running reloading down-counter with a small register port. A prescaler counts pulses of a reference clock enable and produces a count tick at one of eight selectable rates. Each tick moves the counter one step down. On the tick at which the counter already holds zero, the counter takes a new start value from a reload register and an underflow flag is set. If interrupts are enabled, the flag raises an interrupt line.

The timer has no stop or disable control, so it always runs. Software sets the period by writing the reload register. Start values of zero and one are refused, which keeps the counter from ever sitting idle. Software acknowledges an underflow by writing a one to the flag position of the control register.

Top module: `mod_down_timer`

## Requirements
- R1: After reset the reload register (address 0) reads 0xFF, the control register (address 1) reads 0x00 and irq is low.
- R2: The counter steps down by one on each count tick. On a tick at which it holds 0x00 it loads the reload value and keeps counting. Underflows are therefore spaced (reload + 1) ticks apart, with no way to stop the count.
- R3: A write of 0x00 or 0x01 to address 0 is refused. The register keeps its last accepted value, a read returns that value, and the period does not change.
- R4: Control register layout: bit 7 is the interrupt enable, bit 6 is the underflow flag, bits 5 to 3 always read zero and bits 2 to 0 are the rate select. Every value written to bits 7 and 2:0 reads back unchanged.
- R5: The underflow flag is set on the tick at which the counter holds 0x00. irq is high exactly while both the flag and the interrupt enable are set.
- R6: Writing the control register with bit 6 = 1 clears the flag. Writing it with bit 6 = 0 leaves the flag unchanged.
- R7: If an underflow and a clearing write occur in the same cycle, the flag ends up set.
- R8: Rate select code s gives one count tick every 8 * 2^s reference pulses (000 gives 8, 111 gives 1024). After reset the divider is 8. A new code takes effect from the next tick.
- R9: The prescaler advances only on cycles with ref_tick high. Halving the ref_tick rate doubles the underflow spacing measured in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | Reference clock enable, one pulse per reference period |
| addr | input | 1 | Register select: 0 reload, 1 control |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The spacing between successive underflows is measured in clock cycles. It is measured across all eight rate codes with a short period, and across a spread of reload values, including 2 and 255, at the fastest rate. This separates an error in the divider from an off-by-one in the reload. The untouched reset state is measured as well, to confirm the default period of 256 ticks at divide-by-8. A half-rate ref_tick pattern shows whether the prescaler counts reference pulses rather than clocks. A clearing write timed to land on the exact underflow cycle exposes the wrong priority between setting and clearing the flag.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
   localparam int DATA_W     = 8;
   localparam int CTL_IEN    = 7;
   localparam int CTL_FLG    = 6;
   localparam int SEL_W      = 3;
   localparam int BASE_LOG2  = 3;
   localparam int MIN_RELOAD = 2;

   typedef enum logic {
      REG_RELOAD  = 1'b0,
      REG_CONTROL = 1'b1
   } mdt_reg_e;
endpackage

// File: rtl/mdt_prescaler.sv
module mdt_prescaler #(
   parameter int BASE_LOG2 = 3,
   parameter int SEL_W     = 3,
   parameter bit REG_TICK  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int PS_W = BASE_LOG2 + (1 << SEL_W) - 1;

   logic [PS_W-1:0] ps_cnt;
   logic [PS_W-1:0] tap_mask;
   logic            hit;

   if (BASE_LOG2 < 1) begin : g_bad_base
      $error("mdt_prescaler: BASE_LOG2 must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("mdt_prescaler: SEL_W must be 1..4");
   end

   // low bits that must all be ones for the selected divider
   always_comb begin
      for (int i = 0; i < PS_W; i++) begin
         tap_mask[i] = (i < BASE_LOG2 + int'(sel));
      end
   end

   assign hit = ref_tick && (&(ps_cnt | ~tap_mask));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ps_cnt <= '0;
      end else if (ref_tick) begin
         ps_cnt <= ps_cnt + 1'b1;
      end
   end

   if (REG_TICK) begin : g_reg_tick
      logic tick_q;
      always_ff @(posedge clk) begin
         if (!rst_n) tick_q <= 1'b0;
         else        tick_q <= hit;
      end
      assign tick = tick_q;

      // R9
      tick_after_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |-> $past(ref_tick));
   end else begin : g_comb_tick
      assign tick = hit;

      // R9
      tick_needs_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |-> ref_tick);
   end

   // R9
   ps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_tick |=> $stable(ps_cnt));
endmodule

// File: rtl/mdt_reload_reg.sv
module mdt_reload_reg #(
   parameter int CNT_W   = 8,
   parameter int MIN_VAL = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] reload
);
   logic accept;

   if (MIN_VAL < 0 || MIN_VAL >= (1 << CNT_W)) begin : g_bad_min
      $error("mdt_reload_reg: MIN_VAL out of range");
   end

   assign accept = wr && (int'(wdata) >= MIN_VAL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reload <= '1;
      end else if (accept) begin
         reload <= wdata;
      end
   end

   // R3
   reload_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && int'(wdata) < MIN_VAL) |=> $stable(reload));

   // R3
   reload_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(reload) >= MIN_VAL);
endmodule

// File: rtl/mdt_count_core.sv
module mdt_count_core #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] reload,
   input  logic             flag_clr,
   output logic             flag
);
   logic [CNT_W-1:0] count;
   logic             at_zero;
   logic             flag_set;

   if (CNT_W < 2) begin : g_bad_w
      $error("mdt_count_core: CNT_W must be at least 2");
   end

   assign at_zero  = (count == '0);
   assign flag_set = tick && at_zero;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '1;
      end else if (tick) begin
         if (at_zero) count <= reload;
         else         count <= count - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else if (flag_set) begin
         flag <= 1'b1;
      end else if (flag_clr) begin
         flag <= 1'b0;
      end
   end

   // R2
   count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count != '0) |=> count == $past(count) - 1'b1);

   // R2
   count_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0) |=> count == $past(reload));

   // R5
   flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(tick));

   // R7
   flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '0) |=> flag);

   // R6
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !(tick && count == '0)) |=> !flag);
endmodule

// File: rtl/mod_down_timer.sv
module mod_down_timer
   import mdt_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int ADDR_W    = 1,
   parameter bit REG_TICK  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_tick,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   localparam int PAD_W = DATA_W - CNT_W;

   logic             sel_reload;
   logic             sel_ctrl;
   logic             irq_en;
   logic [SEL_W-1:0] rate_sel;
   logic             cnt_tick;
   logic             flag;
   logic [CNT_W-1:0] reload;
   logic             flag_clr;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("mod_down_timer: CNT_W must be 2..DATA_W");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("mod_down_timer: ADDR_W must be at least 1");
   end

   assign sel_reload = (addr == ADDR_W'(REG_RELOAD));
   assign sel_ctrl   = (addr == ADDR_W'(REG_CONTROL));
   assign flag_clr   = wr_en && sel_ctrl && wr_data[CTL_FLG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_en   <= 1'b0;
         rate_sel <= '0;
      end else if (wr_en && sel_ctrl) begin
         irq_en   <= wr_data[CTL_IEN];
         rate_sel <= wr_data[SEL_W-1:0];
      end
   end

   mdt_prescaler #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W),
      .REG_TICK  (REG_TICK)
   ) u_presc (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .sel      (rate_sel),
      .tick     (cnt_tick)
   );

   mdt_reload_reg #(
      .CNT_W   (CNT_W),
      .MIN_VAL (MIN_RELOAD)
   ) u_reload (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (wr_en && sel_reload),
      .wdata  (wr_data[CNT_W-1:0]),
      .reload (reload)
   );

   mdt_count_core #(
      .CNT_W (CNT_W)
   ) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .reload   (reload),
      .flag_clr (flag_clr),
      .flag     (flag)
   );

   logic [DATA_W-1:0] reload_rd;
   if (PAD_W > 0) begin : g_pad
      assign reload_rd = {{PAD_W{1'b0}}, reload};
   end else begin : g_nopad
      assign reload_rd = reload;
   end

   always_comb begin
      rd_data = '0;
      if (sel_reload) begin
         rd_data = reload_rd;
      end else if (sel_ctrl) begin
         rd_data[CTL_IEN]     = irq_en;
         rd_data[CTL_FLG]     = flag;
         rd_data[SEL_W-1:0]   = rate_sel;
      end
   end

   assign irq = flag && irq_en;

   // R5
   irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   // R4
   ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel_ctrl) |=> ($stable(irq_en) && $stable(rate_sel)));
endmodule

// File: tb/mod_down_timer_tb.sv
module mod_down_timer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int WAIT_MAX   = 9000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ref_tick = 1'b1;
   logic [0:0] addr = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       irq;

   int  checks = 0;
   int  failures = 0;
   int  cyc = 0;
   bit  ref_half = 1'b0;
   bit  done = 1'b0;

   mod_down_timer dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_tick (ref_tick),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .irq      (irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;
   always @(negedge clk) ref_tick <= ref_half ? ~ref_tick : 1'b1;

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0; addr = 1'b1;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      addr = a; #1;
      d = rd_data;
      addr = 1'b1;
   endtask

   // waits for the flag to read 1 (addr idles at control); returns cycle stamp
   task automatic wait_flag(input string req, output int t);
      int n = 0;
      t = -1;
      do begin
         @(posedge clk); #1;
         n++;
      end while (!rd_data[6] && n < WAIT_MAX);
      if (rd_data[6]) t = cyc;
      else begin
         failures++;
         $display("FAIL %s actual=timeout expected=flag", req);
      end
   endtask

   // underflow spacing in clock cycles for reload n and rate code s
   task automatic measure(input int n, input int s, input bit ien,
                          output int gap, output int t_last);
      int t1, t2, t3;
      logic [7:0] c = {ien, 1'b1, 3'b000, 3'(s)};
      wr(1'b0, 8'(n));
      wr(1'b1, c);
      wait_flag("R2", t1);
      wr(1'b1, c);
      wait_flag("R2", t2);
      wr(1'b1, c);
      wait_flag("R2", t3);
      gap = t3 - t2;
      t_last = t3;
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      int gap, t, t0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      rd(1'b0, d); check("R1 reload reset", d, 8'hFF);
      rd(1'b1, d); check("R1 control reset", d, 8'h00);
      check("R1 irq reset", irq, 0);

      // R8 default rate with reset reload 0xFF: 256 ticks of 8
      wait_flag("R8", t0);
      wr(1'b1, 8'h40);
      wait_flag("R8", t);
      check("R8 default period", t - t0, 256 * 8);

      // R8 all rate codes, reload 2
      for (int s = 0; s < 8; s++) begin
         measure(2, s, 1'b0, gap, t);
         check($sformatf("R8 rate code %0d", s), gap, 3 * (8 << s));
      end

      // R2 reload sweep at divide-by-8
      for (int n = 2; n < 256; n += 23) begin
         measure(n, 0, 1'b0, gap, t);
         check($sformatf("R2 reload %0d", n), gap, (n + 1) * 8);
      end
      measure(255, 0, 1'b0, gap, t);
      check("R2 reload 255", gap, 256 * 8);

      // R3 refused reload values
      wr(1'b0, 8'h05);
      wr(1'b0, 8'h00);
      rd(1'b0, d); check("R3 write 0x00 refused", d, 5);
      wr(1'b0, 8'h01);
      rd(1'b0, d); check("R3 write 0x01 refused", d, 5);
      measure(5, 0, 1'b0, gap, t);
      wr(1'b0, 8'h01);
      wr(1'b1, 8'h40);
      wait_flag("R3", t0);
      wr(1'b1, 8'h40);
      wait_flag("R3", t);
      check("R3 period kept", t - t0, 6 * 8);

      // R5 irq with enable set, and gated when clear
      measure(3, 0, 1'b1, gap, t);
      check("R5 irq with enable", irq, 1);
      measure(3, 0, 1'b0, gap, t);
      check("R5 irq gated", irq, 0);

      // R6 writing 0 to bit 6 keeps the flag, writing 1 clears it
      wr(1'b1, 8'h00);
      rd(1'b1, d); check("R6 zero keeps flag", d[6], 1);
      wr(1'b1, 8'h40);
      rd(1'b1, d); check("R6 one clears flag", d[6], 0);

      // R4 layout: unimplemented bits read zero
      wr(1'b1, 8'hFD);
      rd(1'b1, d); check("R4 control readback", d & 8'hBF, 8'h85);
      wr(1'b1, 8'h7A);
      rd(1'b1, d); check("R4 control readback 2", d & 8'hBF, 8'h02);

      // R7 clearing write on the underflow cycle
      measure(2, 0, 1'b0, gap, t);
      wr(1'b1, 8'h40);
      do begin
         @(posedge clk); #1;
      end while (cyc < t + 23);
      @(negedge clk);
      addr = 1'b1; wr_data = 8'h40; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
      rd(1'b1, d); check("R7 set wins", d[6], 1);

      // R9 half-rate reference pulses double the spacing
      ref_half = 1'b1;
      measure(2, 0, 1'b0, gap, t);
      check("R9 half ref rate", gap, 3 * 8 * 2);
      ref_half = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule